// File: doc/BRIEF.md
# DRAM Refresh Scheduler and Arbiter

This block keeps a synchronous DRAM refreshed without the main memory controller having to track refresh timing. A free-running interval counter, reloaded from a run-time cycle count (the average refresh period divided by the clock period), adds one outstanding refresh to a small saturating backlog each time it expires. While the backlog is non-empty the block asks the controller for the command bus. Once the bus is granted, the block drives the refresh sequence on its own command pins. If some bank is still open, it first closes every bank with a precharge-all. It then waits the precharge delay, issues the auto-refresh, and keeps the bus quiet for the refresh cycle time.

The backlog lets the controller postpone refreshes to serve traffic. When eight refreshes are outstanding, an urgent flag tells the controller that it must yield. A separate request puts the device into self-refresh by dropping the clock enable together with the refresh encoding. Dropping that request brings the device back out: the clock enable is raised under a deselect and the refresh cycle time is waited out. All delays are given in clock cycles, computed by software as the nanosecond figure divided by the clock period and rounded up.

Top module: `refresh_sched`

## Requirements
- R1: While reset is held low, the outputs show clock enable high, chip select high (deselect), request low, urgent low and self-refresh acknowledge low.
- R2: With no grant, request rises exactly `interval_cycles` clock edges after reset is released, and one further refresh becomes outstanding every `interval_cycles` edges after that.
- R3: The backlog holds at most 8 refreshes, and expiries beyond that are dropped. Urgent is high exactly while 8 refreshes are outstanding, and request is always high when urgent is high.
- R4: Every command-bus cycle in which request is low is a deselect (chip select high). No command is driven before a grant is seen while request is high.
- R5: If grant is high in an idle cycle with a refresh outstanding and `banks_idle` high, the next cycle carries an auto-refresh: clock enable high, chip select, row strobe and column strobe low, write enable high.
- R6: If `banks_idle` is low at that point, the next cycle instead carries a precharge-all: clock enable high, chip select, row strobe and write enable low, column strobe high, `a10` high. The auto-refresh follows exactly `trp_cycles` cycles after it, with deselects in between, and `banks_idle` is not sampled again.
- R7: After an auto-refresh, the next `trc_cycles-1` cycles are deselects with request held high. The block is idle again `trc_cycles` cycles after the refresh, so back-to-back refreshes under a constant grant are `trc_cycles+1` cycles apart.
- R8: Each auto-refresh removes exactly one outstanding refresh. A full backlog of 8 drains with exactly 8 auto-refresh commands, after which request falls.
- R9: Self-refresh entry, on grant with `self_refresh_req` high, is the auto-refresh encoding with clock enable low. From the next cycle the clock enable stays low, the command lines deselect and the acknowledge is high. The interval counter is frozen for as long as this lasts.
- R10: When `self_refresh_req` falls, the next cycle raises clock enable under a deselect and drops the acknowledge. No command follows for `trc_cycles` cycles, and any outstanding refresh is issued in the cycle after that.
- R11: When a self-refresh request and an outstanding refresh are both present at a grant, self-refresh entry is performed first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| interval_cycles | input | 16 | Clock cycles between refresh requests |
| trp_cycles | input | 8 | Precharge delay in clock cycles |
| trc_cycles | input | 8 | Refresh cycle time in clock cycles |
| banks_idle | input | 1 | High when every bank is precharged |
| grant | input | 1 | Controller hands the command bus to this block |
| self_refresh_req | input | 1 | Level request to stay in self-refresh |
| req | output | 1 | Refresh outstanding or sequence in progress |
| urgent | output | 1 | Backlog full; controller must yield |
| self_refresh_ack | output | 1 | Device is held in self-refresh |
| cke | output | 1 | DRAM clock enable |
| cs_n | output | 1 | DRAM chip select, active low |
| ras_n | output | 1 | DRAM row strobe, active low |
| cas_n | output | 1 | DRAM column strobe, active low |
| we_n | output | 1 | DRAM write enable, active low |
| a10 | output | 1 | Address bit 10, set for precharge-all |

## Verification
A wrong backlog count can only be seen indirectly. It shows as an urgent flag one interval early or late, or as a drain that issues one refresh too many or too few before request falls. The bench counts both, to the exact cycle. A sequencer stuck or mis-timed in its wait states shows within a few cycles as a refresh that arrives off its precharge distance, as a command inside the refresh cycle window, or as request falling early. A timer that keeps running during self-refresh goes unnoticed until exit, where the backlog is too large and request stays high past the single expected refresh.

// File: rtl/rfsh_pkg.sv
// Shared types for the refresh scheduler: command-pin bundle, the fixed
// command encodings it drives, and the sequencer state encoding.
package rfsh_pkg;

    typedef struct packed {
        logic cke;
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
        logic a10;
    } dram_pins_t;

    // Bus parked: clock running, chip deselected.
    localparam dram_pins_t PINS_DESELECT  = '{cke: 1'b1, cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1, a10: 1'b0};
    // Close every bank.
    localparam dram_pins_t PINS_PRECH_ALL = '{cke: 1'b1, cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0, a10: 1'b1};
    // Auto refresh.
    localparam dram_pins_t PINS_AUTO_REF  = '{cke: 1'b1, cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1, a10: 1'b0};
    // Self-refresh entry: refresh code with clock enable dropping.
    localparam dram_pins_t PINS_SELF_IN   = '{cke: 1'b0, cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1, a10: 1'b0};
    // Held in self-refresh.
    localparam dram_pins_t PINS_SELF_HOLD = '{cke: 1'b0, cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1, a10: 1'b0};

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_PRECH,
        SQ_WAIT_RP,
        SQ_REFRESH,
        SQ_WAIT_RC,
        SQ_SELF_IN,
        SQ_SELF_HOLD,
        SQ_SELF_OUT
    } seq_state_t;

endpackage

// File: rtl/rfsh_interval_timer.sv
// Interval timer: counts enabled clock cycles and pulses `tick` in the
// cycle that completes each period of `interval_cycles` cycles.
// Assumes the period may change at any time; a comparison (not equality)
// keeps a shrinking period from wrapping the counter. A zero period
// ticks every enabled cycle.
module rfsh_interval_timer #(
    parameter int IW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [IW-1:0] period,
    output logic          tick
);
    logic [IW-1:0] count;
    logic [IW:0]   count_plus;

    // Period complete when the next count would reach the period.
    always_comb begin
        count_plus = {1'b0, count} + 1'b1;
        tick       = run && (count_plus >= {1'b0, period});
    end

    // Advance while running, restart from zero on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (tick) begin
            count <= '0;
        end else if (run) begin
            count <= count_plus[IW-1:0];
        end
    end
endmodule

// File: rtl/rfsh_backlog.sv
// Backlog of outstanding refreshes: saturating up/down counter.
// An increment and a decrement in the same cycle cancel. Increments at
// the ceiling are dropped; a decrement at zero is ignored.
module rfsh_backlog #(
    parameter int MAX_PEND = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic add,
    input  logic take,
    output logic any,
    output logic full
);
    localparam int CW = $clog2(MAX_PEND + 1);
    localparam logic [CW-1:0] CEIL = CW'(MAX_PEND);

    logic [CW-1:0] level;

    // Status flags from the current level.
    always_comb begin
        any  = (level != '0);
        full = (level == CEIL);
    end

    // Update the level from this cycle's add and take.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level <= '0;
        end else begin
            unique case ({add, take})
                2'b10:   if (level != CEIL) level <= level + 1'b1;
                2'b01:   if (level != '0)   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end
endmodule

// File: rtl/rfsh_sequencer.sv
// Command sequencer. It owns the command pins from grant until the
// refresh or self-refresh sequence has fully timed out.
// Assumes the controller grants the bus only in a cycle where it drives
// nothing itself, and keeps off the bus while `busy` is high. A precharge
// delay or refresh cycle time of 0 or 1 means no wait cycles.
module rfsh_sequencer
    import rfsh_pkg::*;
#(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          grant,
    input  logic          banks_idle,
    input  logic          have_pending,
    input  logic          sr_req,
    input  logic [TW-1:0] trp,
    input  logic [TW-1:0] trc,
    output logic          busy,
    output logic          refresh_sent,
    output logic          timer_run,
    output logic          sr_ack,
    output dram_pins_t    pins
);
    seq_state_t    state, state_nx;
    logic          goal_self, goal_self_nx;
    logic [TW-1:0] waited;
    logic [TW:0]   waited_plus;
    logic          rp_done, rc_done, rp_none, rc_none;
    seq_state_t    goal_state;

    // Delay completion flags; `waited` counts cycles since the command.
    always_comb begin
        waited_plus = {1'b0, waited} + 1'b1;
        rp_done     = waited_plus >= {1'b0, trp};
        rc_done     = waited_plus >= {1'b0, trc};
        rp_none     = trp <= TW'(1);
        rc_none     = trc <= TW'(1);
        goal_state  = goal_self ? SQ_SELF_IN : SQ_REFRESH;
    end

    // Next-state choice; self-refresh wins over a pending auto refresh.
    always_comb begin
        state_nx     = state;
        goal_self_nx = goal_self;
        unique case (state)
            SQ_IDLE: begin
                if (grant && sr_req) begin
                    goal_self_nx = 1'b1;
                    state_nx     = banks_idle ? SQ_SELF_IN : SQ_PRECH;
                end else if (grant && have_pending) begin
                    goal_self_nx = 1'b0;
                    state_nx     = banks_idle ? SQ_REFRESH : SQ_PRECH;
                end
            end
            SQ_PRECH:     state_nx = rp_none ? goal_state : SQ_WAIT_RP;
            SQ_WAIT_RP:   if (rp_done) state_nx = goal_state;
            SQ_REFRESH:   state_nx = rc_none ? SQ_IDLE : SQ_WAIT_RC;
            SQ_WAIT_RC:   if (rc_done) state_nx = SQ_IDLE;
            SQ_SELF_IN:   state_nx = SQ_SELF_HOLD;
            SQ_SELF_HOLD: if (!sr_req) state_nx = SQ_SELF_OUT;
            SQ_SELF_OUT:  state_nx = rc_none ? SQ_IDLE : SQ_WAIT_RC;
            default:      state_nx = SQ_IDLE;
        endcase
    end

    // State, goal and delay-counter registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= SQ_IDLE;
            goal_self <= 1'b0;
            waited    <= '0;
        end else begin
            state     <= state_nx;
            goal_self <= goal_self_nx;
            unique case (state)
                SQ_PRECH, SQ_REFRESH, SQ_SELF_OUT: waited <= TW'(1);
                SQ_WAIT_RP, SQ_WAIT_RC:            waited <= waited_plus[TW-1:0];
                default:                           waited <= '0;
            endcase
        end
    end

    // Pin decode and status from the current state.
    always_comb begin
        busy         = (state != SQ_IDLE);
        refresh_sent = (state == SQ_REFRESH);
        timer_run    = !(state == SQ_SELF_IN || state == SQ_SELF_HOLD);
        sr_ack       = (state == SQ_SELF_HOLD);
        unique case (state)
            SQ_PRECH:     pins = PINS_PRECH_ALL;
            SQ_REFRESH:   pins = PINS_AUTO_REF;
            SQ_SELF_IN:   pins = PINS_SELF_IN;
            SQ_SELF_HOLD: pins = PINS_SELF_HOLD;
            default:      pins = PINS_DESELECT;
        endcase
    end
endmodule

// File: rtl/refresh_sched.sv
// Refresh scheduler and arbiter top. The interval timer feeds a
// saturating backlog, and the sequencer drains it through precharge-all,
// auto refresh and the refresh cycle wait, or runs self-refresh.
// Assumes all delays arrive already converted to clock cycles (rounded up).
module refresh_sched
    import rfsh_pkg::*;
#(
    parameter int IW       = 16,
    parameter int TW       = 8,
    parameter int MAX_PEND = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [IW-1:0] interval_cycles,
    input  logic [TW-1:0] trp_cycles,
    input  logic [TW-1:0] trc_cycles,
    input  logic          banks_idle,
    input  logic          grant,
    input  logic          self_refresh_req,
    output logic          req,
    output logic          urgent,
    output logic          self_refresh_ack,
    output logic          cke,
    output logic          cs_n,
    output logic          ras_n,
    output logic          cas_n,
    output logic          we_n,
    output logic          a10
);
    logic       tick, any_pending, full, busy, refresh_sent, timer_run;
    dram_pins_t pins;

    rfsh_interval_timer #(.IW(IW)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (timer_run),
        .period (interval_cycles),
        .tick   (tick)
    );

    rfsh_backlog #(.MAX_PEND(MAX_PEND)) u_backlog (
        .clk   (clk),
        .rst_n (rst_n),
        .add   (tick),
        .take  (refresh_sent),
        .any   (any_pending),
        .full  (full)
    );

    rfsh_sequencer #(.TW(TW)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .grant        (grant),
        .banks_idle   (banks_idle),
        .have_pending (any_pending),
        .sr_req       (self_refresh_req),
        .trp          (trp_cycles),
        .trc          (trc_cycles),
        .busy         (busy),
        .refresh_sent (refresh_sent),
        .timer_run    (timer_run),
        .sr_ack       (self_refresh_ack),
        .pins         (pins)
    );

    // Handshake flags and pin fan-out.
    always_comb begin
        req    = any_pending || busy;
        urgent = full;
        cke    = pins.cke;
        cs_n   = pins.cs_n;
        ras_n  = pins.ras_n;
        cas_n  = pins.cas_n;
        we_n   = pins.we_n;
        a10    = pins.a10;
    end
endmodule

// File: rtl/refresh_sched_chk.sv
// Port-level protocol checker for refresh_sched, bound into every instance.
module refresh_sched_chk #(
    parameter int TW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic [TW-1:0] trp_cycles,
    input logic [TW-1:0] trc_cycles,
    input logic          req,
    input logic          urgent,
    input logic          self_refresh_ack,
    input logic          cke,
    input logic          cs_n,
    input logic          ras_n,
    input logic          cas_n,
    input logic          we_n,
    input logic          a10
);
    logic is_pall, is_ref;
    assign is_pall = cke && !cs_n && !ras_n && cas_n && !we_n && a10;
    assign is_ref  = cke && !cs_n && !ras_n && !cas_n && we_n;

    AST_URGENT_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        urgent |-> req); // R3
    AST_QUIET_WITHOUT_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !req |-> cs_n); // R4
    AST_PALL_THEN_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (is_pall && trp_cycles > 8'd1) |=> cs_n); // R6
    AST_REF_THEN_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (is_ref && trc_cycles > 8'd1) |=> (cs_n && req)); // R7
    AST_CKE_FALL_IS_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cke) |-> (!cs_n && !ras_n && !cas_n && we_n)); // R9
    AST_ACK_CKE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        self_refresh_ack |-> !cke); // R9
    AST_CKE_RISE_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cke) |-> (cs_n && !self_refresh_ack)); // R10
endmodule

bind refresh_sched refresh_sched_chk #(.TW(TW)) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .trp_cycles       (trp_cycles),
    .trc_cycles       (trc_cycles),
    .req              (req),
    .urgent           (urgent),
    .self_refresh_ack (self_refresh_ack),
    .cke              (cke),
    .cs_n             (cs_n),
    .ras_n            (ras_n),
    .cas_n            (cas_n),
    .we_n             (we_n),
    .a10              (a10)
);

// File: tb/tb_refresh_sched.sv
// Directed bench: one task per scenario, each checking its own results.
module tb_refresh_sched;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] interval_cycles;
    logic [7:0]  trp_cycles, trc_cycles;
    logic        banks_idle, grant, self_refresh_req;
    logic        req, urgent, self_refresh_ack;
    logic        cke, cs_n, ras_n, cas_n, we_n, a10;
    int          checks = 0;
    int          errors = 0;
    bit          finished = 1'b0;

    always #10 clk = ~clk;

    refresh_sched dut (
        .clk(clk), .rst_n(rst_n), .interval_cycles(interval_cycles),
        .trp_cycles(trp_cycles), .trc_cycles(trc_cycles),
        .banks_idle(banks_idle), .grant(grant),
        .self_refresh_req(self_refresh_req), .req(req), .urgent(urgent),
        .self_refresh_ack(self_refresh_ack), .cke(cke), .cs_n(cs_n),
        .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .a10(a10)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic bit is_ref();
        return cke && !cs_n && !ras_n && !cas_n && we_n;
    endfunction

    function automatic bit is_pall();
        return cke && !cs_n && !ras_n && cas_n && !we_n && a10;
    endfunction

    function automatic bit is_sr_entry();
        return !cke && !cs_n && !ras_n && !cas_n && we_n;
    endfunction

    task automatic do_reset(input int iv, input int tp, input int tc);
        rst_n = 1'b0; grant = 1'b0; banks_idle = 1'b1; self_refresh_req = 1'b0;
        interval_cycles = 16'(iv); trp_cycles = 8'(tp); trc_cycles = 8'(tc);
        repeat (3) @(negedge clk);
        chk(cke && cs_n && !req && !urgent && !self_refresh_ack, "R1 reset outputs",
            {cke, cs_n, req, urgent, self_refresh_ack}, 5'b11000);
        rst_n = 1'b1;
    endtask

    // Backlog growth, urgent point, then drain under constant grant.
    task automatic test_interval_and_drain();
        int  first_req = -1, first_urg = -1, nref = 0, last = 0, k = 0;
        bit  cmd_seen = 1'b0, gap_bad = 1'b0, stray = 1'b0;
        do_reset(20, 3, 5);
        for (int i = 1; i <= 200; i++) begin
            @(negedge clk);
            if (req && first_req < 0) first_req = i;
            if (urgent && first_urg < 0) first_urg = i;
            if (!cs_n) cmd_seen = 1'b1;
        end
        chk(first_req == 20, "R2 first request edge", first_req, 20);
        chk(first_urg == 160, "R3 urgent at eighth request", first_urg, 160);
        chk(!cmd_seen, "R4 no command without grant", cmd_seen, 0);
        interval_cycles = 16'd1000;
        grant = 1'b1;
        @(negedge clk);
        chk(is_ref(), "R5 refresh one cycle after grant", is_ref(), 1);
        nref = 1;
        while (req && k < 200) begin
            k++;
            @(negedge clk);
            if (is_ref()) begin
                if (k - last != 6) gap_bad = 1'b1;
                last = k;
                nref++;
            end else if (!cs_n) begin
                stray = 1'b1;
            end
        end
        chk(nref == 8, "R8 drain count (R3 saturation)", nref, 8);
        chk(!gap_bad, "R7 refresh spacing trc+1", gap_bad, 0);
        chk(!stray, "R7 only deselect between refreshes", stray, 0);
        chk(k == 47, "R7 request falls trc after last refresh", k, 47);
        chk(!urgent, "R3 urgent cleared after drain", urgent, 0);
        grant = 1'b0;
    endtask

    // Open bank: precharge-all, trp gap, refresh, trc hold.
    task automatic test_precharge_path();
        do_reset(40, 3, 5);
        banks_idle = 1'b0;
        repeat (40) @(negedge clk);
        chk(req, "R2 request after one interval", req, 1);
        grant = 1'b1;
        @(negedge clk);
        chk(is_pall(), "R6 precharge-all first", {cke, cs_n, ras_n, cas_n, we_n, a10}, 6'b100101);
        for (int i = 1; i <= 2; i++) begin
            @(negedge clk);
            chk(cs_n, "R6 deselect inside trp", cs_n, 1);
        end
        @(negedge clk);
        chk(is_ref(), "R6 refresh trp after precharge", is_ref(), 1);
        for (int i = 1; i <= 4; i++) begin
            @(negedge clk);
            chk(req && cs_n, "R7 quiet and busy inside trc", {req, cs_n}, 2'b11);
        end
        @(negedge clk);
        chk(!req, "R7 idle trc after refresh", req, 0);
        grant = 1'b0;
    endtask

    // Self-refresh priority, hold, frozen timer, exit timing.
    task automatic test_self_refresh();
        bit bad = 1'b0;
        do_reset(30, 3, 4);
        repeat (30) @(negedge clk);
        chk(req, "R2 request before self-refresh", req, 1);
        self_refresh_req = 1'b1;
        grant = 1'b1;
        @(negedge clk);
        chk(is_sr_entry(), "R11 self-refresh entry beats pending refresh",
            {cke, cs_n, ras_n, cas_n, we_n}, 5'b00001);
        @(negedge clk);
        chk(!cke && cs_n && self_refresh_ack, "R9 held in self-refresh",
            {cke, cs_n, self_refresh_ack}, 3'b011);
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (cke || !cs_n || !self_refresh_ack) bad = 1'b1;
        end
        chk(!bad, "R9 self-refresh stable", bad, 0);
        self_refresh_req = 1'b0;
        @(negedge clk);
        chk(cke && cs_n && !self_refresh_ack, "R10 exit deselect",
            {cke, cs_n, self_refresh_ack}, 3'b110);
        bad = 1'b0;
        for (int i = 1; i <= 4; i++) begin
            @(negedge clk);
            if (!cs_n) bad = 1'b1;
        end
        chk(!bad, "R10 no command inside trc after exit", bad, 0);
        @(negedge clk);
        chk(is_ref(), "R10 pending refresh after exit wait", is_ref(), 1);
        repeat (3) @(negedge clk);
        chk(req, "R7 busy after refresh", req, 1);
        @(negedge clk);
        chk(!req, "R9 timer frozen, backlog empty", req, 0);
        grant = 1'b0;
    endtask

    initial begin
        test_interval_and_drain();
        test_precharge_path();
        test_self_refresh();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #(20 * 150000);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule